// File: doc/BRIEF.md
# Twiddle Complex Multiplier

This block multiplies one complex data sample by one complex twiddle factor each cycle. It sits between the butterflies of a streaming FFT pipeline. The data and twiddle words are signed two's complement values of the same width. The twiddle carries two integer bits, one of them the sign, and the remaining bits are fraction. The full-precision product is brought back to the data width by dropping the fractional bits with floor rounding, which rounds toward negative infinity. A valid strobe travels alongside the samples and is delayed by the same number of cycles.

A build-time parameter picks how the complex product is formed. With `MULTS = 3`, three real multipliers are fed by pre-adders and followed by two post-adders. With `MULTS = 4`, four real multipliers are followed by plain sum and difference stages. Both variants keep every intermediate bit until the final rounding step, so they give identical outputs with identical latency. Pipeline registers advance only on cycles that carry valid data.

Top module: `twiddle_cmul`

## Requirements
- R1: `re_o` equals the low DW bits of floor((dr*tr - di*ti) / 2^(DW-2)), where dr, di, tr and ti are the signed data and twiddle inputs.
- R2: `im_o` equals the low DW bits of floor((dr*ti + di*tr) / 2^(DW-2)).
- R3: Rounding is floor, not truncation toward zero. For DW=4, a data value of -1 times a twiddle of 0.25 (code 1) gives -1, which is code 4'hF.
- R4: `vld_o` is `vld_i` delayed by exactly 3 clock cycles. The result for a valid input appears in the same cycle as its delayed strobe.
- R5: The 3-multiplier and 4-multiplier builds give bit-identical `re_o` and `im_o` for every input.
- R6: A twiddle of exactly 1+0j (real code 2^(DW-2), imaginary code 0) returns the data sample unchanged.
- R7: While `rst_n` is low, and for the 3 cycles after its release, `vld_o` is low unless a valid input has reached the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| vld_i | input | 1 | Input sample is valid |
| dat_re_i | input | DW | Data real part, signed |
| dat_im_i | input | DW | Data imaginary part, signed |
| tw_re_i | input | DW | Twiddle real part, signed, 2 integer bits |
| tw_im_i | input | DW | Twiddle imaginary part, signed, 2 integer bits |
| vld_o | output | 1 | Output sample is valid |
| re_o | output | DW | Rounded product real part, signed |
| im_o | output | DW | Rounded product imaginary part, signed |

## Verification
With DW=4, the bench streams all 65536 combinations of data and twiddle codes through both multiplier builds. A periodic gap in the valid strobe shows whether registers hold off on idle cycles without losing alignment. The arithmetic reference catches sign-extension and pre-adder overflow errors, because extreme codes such as -8 and -2.0 are included. A negative product with a fractional remainder separates floor rounding from truncation. The unit twiddle shows that the shift position is correct. Comparing the two builds sample by sample shows any bit where the structures diverge. A reset applied while data is in flight shows that the valid pipeline is cleared.

// File: rtl/twiddle_cmul.sv
module twiddle_cmul #(
  parameter int DW    = 16,
  parameter int MULTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] dat_re_i,
  input  logic signed [DW-1:0] dat_im_i,
  input  logic signed [DW-1:0] tw_re_i,
  input  logic signed [DW-1:0] tw_im_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] re_o,
  output logic signed [DW-1:0] im_o
);
  localparam int FB = DW - 2;
  localparam int AW = DW + 1;
  localparam int MW = 2 * DW + 2;
  localparam int SW = 2 * DW + 3;
  localparam logic signed [DW-1:0] ONE = DW'(1 << FB);

  logic v1, v2, v3;
  logic [1:0] age;
  logic signed [SW-1:0] re3, im3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {v1, v2, v3} <= '0;
      age <= '0;
    end else begin
      {v1, v2, v3} <= {vld_i, v1, v2};
      if (age != 2'd3) age <= age + 2'd1;
    end

  generate
    if (MULTS == 3) begin : g_three
      logic signed [AW-1:0] sa, sb, sc;
      logic signed [DW-1:0] ar1, ai1, br1;
      logic signed [MW-1:0] k1, k2, k3;
      always_ff @(posedge clk) begin
        if (vld_i) begin
          sa  <= AW'(dat_re_i) + AW'(dat_im_i);
          sb  <= AW'(tw_im_i) - AW'(tw_re_i);
          sc  <= AW'(tw_re_i) + AW'(tw_im_i);
          ar1 <= dat_re_i;
          ai1 <= dat_im_i;
          br1 <= tw_re_i;
        end
        if (v1) begin
          k1 <= MW'(br1) * MW'(sa);
          k2 <= MW'(ar1) * MW'(sb);
          k3 <= MW'(ai1) * MW'(sc);
        end
        if (v2) begin
          re3 <= SW'(k1) - SW'(k3);
          im3 <= SW'(k1) + SW'(k2);
        end
      end
    end else begin : g_four
      logic signed [DW-1:0] ar1, ai1, br1, bi1;
      logic signed [MW-1:0] p0, p1, p2, p3;
      always_ff @(posedge clk) begin
        if (vld_i) begin
          ar1 <= dat_re_i;
          ai1 <= dat_im_i;
          br1 <= tw_re_i;
          bi1 <= tw_im_i;
        end
        if (v1) begin
          p0 <= MW'(ar1) * MW'(br1);
          p1 <= MW'(ai1) * MW'(bi1);
          p2 <= MW'(ar1) * MW'(bi1);
          p3 <= MW'(ai1) * MW'(br1);
        end
        if (v2) begin
          re3 <= SW'(p0) - SW'(p1);
          im3 <= SW'(p2) + SW'(p3);
        end
      end
    end
  endgenerate

  assign vld_o = v3;
  assign re_o  = re3[FB +: DW];
  assign im_o  = im3[FB +: DW];

  p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (vld_o == $past(vld_i, 3)));

  p_unit_twiddle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(vld_i, 3) && $past(tw_re_i, 3) == ONE && $past(tw_im_i, 3) == '0)
    |-> (re_o == $past(dat_re_i, 3) && im_o == $past(dat_im_i, 3)));

  p_zero_twiddle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(vld_i, 3) && $past(tw_re_i, 3) == '0 && $past(tw_im_i, 3) == '0)
    |-> (re_o == '0 && im_o == '0));

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n |-> !vld_o);

  p_early_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !vld_o);
endmodule

// File: tb/twiddle_cmul_bench.sv
`timescale 1ns/1ps
module twiddle_cmul_bench;
  localparam int DW = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld_i = 1'b0;
  logic signed [DW-1:0] dr = '0, di = '0, tr = '0, ti = '0;
  logic vo3, vo4;
  logic signed [DW-1:0] re3, im3, re4, im4;
  int checks = 0, fails = 0;
  int hdr[3], hdi[3], htr[3], hti[3];
  bit hv[3];

  always #2.5 clk = ~clk;

  twiddle_cmul #(.DW(DW), .MULTS(3)) u_twiddle_cmul (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .dat_re_i(dr), .dat_im_i(di),
    .tw_re_i(tr), .tw_im_i(ti), .vld_o(vo3), .re_o(re3), .im_o(im3));
  twiddle_cmul #(.DW(DW), .MULTS(4)) u_twiddle_cmul_m4 (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .dat_re_i(dr), .dat_im_i(di),
    .tw_re_i(tr), .tw_im_i(ti), .vld_o(vo4), .re_o(re4), .im_o(im4));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fl(int x);
    int q = x >>> (DW - 2);
    logic signed [DW-1:0] t = q[DW-1:0];
    return int'(t);
  endfunction

  task automatic clear_hist();
    for (int k = 0; k < 3; k++) hv[k] = 1'b0;
  endtask

  task automatic step(bit v, int a, int b, int c, int d);
    int er, ei;
    chk("R4 vld_o m3", int'(vo3), int'(hv[2]));
    chk("R4 vld_o m4", int'(vo4), int'(hv[2]));
    if (hv[2]) begin
      er = fl(hdr[2] * htr[2] - hdi[2] * hti[2]);
      ei = fl(hdr[2] * hti[2] + hdi[2] * htr[2]);
      chk("R1 re m3", int'(re3), er);
      chk("R1 re m4", int'(re4), er);
      chk("R2 im m3", int'(im3), ei);
      chk("R2 im m4", int'(im4), ei);
      chk("R5 re match", int'(re3), int'(re4));
      chk("R5 im match", int'(im3), int'(im4));
      if (htr[2] == 4 && hti[2] == 0) begin
        chk("R6 unit re", int'(re3), hdr[2]);
        chk("R6 unit im", int'(im3), hdi[2]);
      end
      if (hdr[2] == -1 && hdi[2] == 0 && htr[2] == 1 && hti[2] == 0) begin
        chk("R3 floor m3", int'(re3), -1);
        chk("R3 floor m4", int'(re4), -1);
      end
    end
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hdr[k] = hdr[k-1]; hdi[k] = hdi[k-1];
      htr[k] = htr[k-1]; hti[k] = hti[k-1];
    end
    hv[0] = v; hdr[0] = a; hdi[0] = b; htr[0] = c; hti[0] = d;
    vld_i = v;
    dr = DW'(a); di = DW'(b); tr = DW'(c); ti = DW'(d);
    @(negedge clk);
  endtask

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    chk("R7 vld_o in reset m3", int'(vo3), 0);
    chk("R7 vld_o in reset m4", int'(vo4), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      logic signed [DW-1:0] a = i[3:0], b = i[7:4], c = i[11:8], d = i[15:12];
      step((i % 7) != 3, int'(a), int'(b), int'(c), int'(d));
    end
    step(1'b1, 5, -3, 4, 0);
    step(1'b1, -8, 7, -8, -8);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 cleared in flight m3", int'(vo3), 0);
    chk("R7 cleared in flight m4", int'(vo4), 0);
    clear_hist();
    vld_i = 1'b0;
    rst_n = 1'b1;
    step(1'b1, 3, 2, 4, 0);
    step(1'b0, 0, 0, 0, 0);
    step(1'b1, -1, 0, 1, 0);
    for (int k = 0; k < 5; k++) step(1'b0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule